// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Forced Parity

This block serializes bytes onto an asynchronous line. A holding register takes one byte per write. When the shift stage is free, the byte moves into it and is sent as one frame: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Each bit lasts a fixed number of pulses of a baud enable. That enable comes from an external divisor counter and runs at sixteen times the bit rate. As an example, a 1.8432 MHz clock divided by 16 × 96 gives 1200 bit/s.

An 8-bit line control value sets the frame layout. It selects the word length, the stop-bit count, whether parity is present, and which parity is used: odd, even, a constant 1 or a constant 0. A break bit pulls the line low while frame timing keeps running underneath it. The layout fields are captured when a byte enters the shift stage. The break bit acts at once.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `thr_empty` is 1 and `tx_empty` is 1. While break is off and both stages are empty, the line stays at 1.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the optional parity bit, then the stop bits at 1. Every bit lasts 16 baud-enable pulses.
- R3: `lcr[1:0]` picks the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only the low bits of the byte that fit the word length are sent.
- R4: `lcr[2]` = 0 gives one stop bit. `lcr[2]` = 1 gives two.
- R5: When `lcr[3]` = 0, no parity bit is sent, whatever the values of `lcr[5:4]`.
- R6: When `lcr[3]` = 1 and `lcr[5]` = 0, `lcr[4]` = 0 makes the count of ones in data plus parity odd, and `lcr[4]` = 1 makes it even.
- R7: When `lcr[3]` = 1 and `lcr[5]` = 1, the parity bit is the constant 1 if `lcr[4]` = 0 and the constant 0 if `lcr[4]` = 1.
- R8: While `lcr[6]` = 1, `txd` is 0 from the next cycle on. A frame in progress keeps its timing, and when break is released the line shows the current bit of that frame.
- R9: A write clears `thr_empty` on the next cycle. `thr_empty` sets again when the byte moves to the shift stage. `tx_empty` is 1 only when both the holding register and the shift stage are empty.
- R10: `lcr[7]` has no effect on the transmitted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| lcr | input | 8 | Line control: [1:0] length, [2] stop, [3] parity on, [4] even, [5] stick, [6] break, [7] unused here |
| txd | output | 1 | Serial output line (registered) |
| thr_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shift stage are both empty |

## Verification
The assertions assume two things about the inputs: `wr_en` is pulsed only while `thr_empty` is 1, and the layout fields of `lcr` stay stable from a write until that frame has left. With those assumptions, every frame seen on the line matches the byte queued for it. The stimulus meets both. The write task waits for `thr_empty` before it strobes. Line control changes only after the line has drained: queue empty, monitor idle and `tx_empty` high. The baud enable is driven at several spacings, and no assertion depends on its phase relative to a load.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int MIN_WORD = 5;
  localparam int LCR_W    = 8;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       brk;
  } line_cfg_t;

  function automatic line_cfg_t decode_cfg(input logic [LCR_W-1:0] v);
    line_cfg_t c;
    c.wlen      = v[1:0];
    c.stop2     = v[2];
    c.par_en    = v[3];
    c.par_even  = v[4];
    c.par_stick = v[5];
    c.brk       = v[6];
    return c;
  endfunction

  function automatic int word_bits(input logic [1:0] wlen);
    return MIN_WORD + int'(wlen);
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_en) begin
      data_q  <= wr_data;
      empty_q <= 1'b0;
    end else if (take) begin
      empty_q <= 1'b1;
    end
  end

  assign hold_data = data_q;
  assign empty     = empty_q;

  a_r9_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !empty);
  a_r9_take_clears: assert property (@(posedge clk) disable iff (rst)
    take && !wr_en |=> empty);
endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wlen,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              par_bit
);
  import sertx_pkg::*;

  logic ones;

  always_comb begin
    int nb;
    nb   = word_bits(wlen);
    ones = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) ones = ones ^ data[i];
    end
    if (par_stick) par_bit = ~par_even;
    else           par_bit = par_even ? ones : ~ones;
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [1:0]         wlen,
  input  logic               par_en,
  input  logic               par_bit,
  input  logic               stop2,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);
  import sertx_pkg::*;

  logic [FRAME_W-1:0] dext;
  assign dext = FRAME_W'(data);

  always_comb begin
    int nb;
    int total;
    nb = word_bits(wlen);
    for (int j = 0; j < FRAME_W; j++) begin
      if (j == 0)                   frame[j] = 1'b0;
      else if (j <= nb)             frame[j] = dext[j-1];
      else if (par_en && j == nb+1) frame[j] = par_bit;
      else                          frame[j] = 1'b1;
    end
    total = 1 + nb + (par_en ? 1 : 0) + 1 + (stop2 ? 1 : 0);
    len   = CNT_W'(total);
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int FRAME_W    = 12,
  parameter int CNT_W      = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               baud_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   len_in,
  output logic               busy,
  output logic               line_bit
);
  localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(OVERSAMPLE - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   left_q;
  logic [TW-1:0]      tcnt_q;
  logic               busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      tcnt_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      frame_q <= frame_in;
      left_q  <= len_in;
      tcnt_q  <= '0;
    end else if (busy_q && baud_tick) begin
      if (tcnt_q == LAST_TICK) begin
        tcnt_q  <= '0;
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        left_q  <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign line_bit = frame_q[0];

  a_r2_start_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !line_bit);
  a_r2_steady_between_ticks: assert property (@(posedge clk) disable iff (rst)
    busy && !baud_tick |=> $stable(frame_q) && $stable(left_q));
  a_r4_count_live: assert property (@(posedge clk) disable iff (rst)
    busy |-> left_q != '0);
  a_r2_frame_ends: assert property (@(posedge clk) disable iff (rst)
    busy && baud_tick && tcnt_q == LAST_TICK && left_q == CNT_W'(1) |=> !busy);
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic [7:0]        lcr,
  output logic              txd,
  output logic              thr_empty,
  output logic              tx_empty
);
  import sertx_pkg::*;

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  line_cfg_t          cfg;
  logic               unused_dlab;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_empty;
  logic               take;
  logic               par_bit;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               busy;
  logic               line_bit;
  logic               txd_q;

  assign cfg         = decode_cfg(lcr);
  assign unused_dlab = lcr[7];
  assign take        = !hold_empty && !busy;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .hold_data(hold_data), .empty(hold_empty)
  );

  sertx_parity #(.DATA_W(DATA_W)) u_parity (
    .data(hold_data), .wlen(cfg.wlen), .par_even(cfg.par_even),
    .par_stick(cfg.par_stick), .par_bit(par_bit)
  );

  sertx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data(hold_data), .wlen(cfg.wlen), .par_en(cfg.par_en), .par_bit(par_bit),
    .stop2(cfg.stop2), .frame(frame), .len(len)
  );

  sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .load(take),
    .frame_in(frame), .len_in(len), .busy(busy), .line_bit(line_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)          txd_q <= 1'b1;
    else if (cfg.brk) txd_q <= 1'b0;
    else if (busy)    txd_q <= line_bit;
    else              txd_q <= 1'b1;
  end

  assign txd       = txd_q;
  assign thr_empty = hold_empty;
  assign tx_empty  = hold_empty && !busy;

  a_r8_break_low: assert property (@(posedge clk) disable iff (rst)
    lcr[6] |=> !txd);
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
    !lcr[6] && tx_empty |=> txd);
endmodule

// File: tb/sertx_core_bench.sv
module sertx_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 1'b0;
  logic [7:0] lcr = 8'h03;
  logic       txd, thr_empty, tx_empty;

  int checks = 0;
  int errors = 0;
  int tick_p = 1;
  int tcnt = 0;
  bit mon_en = 1'b1;
  bit mon_busy = 1'b0;
  logic prev_txd = 1'b1;

  logic [15:0] q_bits[$];
  int          q_len[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  sertx_core u_sertx_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .lcr(lcr), .txd(txd),
    .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [7:0] d, input logic [7:0] c,
                                    output logic [15:0] b, output int n);
    int nb;
    logic ones;
    nb = 5 + int'(c[1:0]);
    b = '1; n = 0; ones = 1'b0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin
      b[n] = d[i]; ones = ones ^ d[i]; n++;
    end
    if (c[3]) begin
      if (c[5]) b[n] = ~c[4];
      else      b[n] = c[4] ? ones : ~ones;
      n++;
    end
    b[n] = 1'b1; n++;
    if (c[2]) begin b[n] = 1'b1; n++; end
  endfunction

  initial forever begin
    @(negedge clk);
    tcnt = (tcnt + 1 >= tick_p) ? 0 : tcnt + 1;
    baud_tick = (tcnt == 0);
  end

  initial forever begin
    @(negedge clk);
    if (mon_en && !rst && prev_txd && !txd) begin
      mon_busy = 1'b1;
      if (q_len.size() == 0) begin
        chk(1'b0, "R2 unexpected start", 0, 1);
      end else begin
        logic [15:0] eb, got;
        int n;
        string tg;
        eb = q_bits.pop_front(); n = q_len.pop_front(); tg = q_tag.pop_front();
        got = '1;
        repeat (8*tick_p) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
          repeat (16*tick_p) @(negedge clk);
          got[k] = txd;
        end
        chk(got == eb, tg, int'(got), int'(eb));
      end
      mon_busy = 1'b0;
    end
    prev_txd = txd;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  task automatic write_byte(input logic [7:0] d);
    while (!thr_empty) @(negedge clk);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input string tag);
    logic [15:0] b;
    int n;
    while (!thr_empty) @(negedge clk);
    exp_frame(d, lcr, b, n);
    q_bits.push_back(b); q_len.push_back(n); q_tag.push_back(tag);
    write_byte(d);
  endtask

  task automatic drain();
    @(negedge clk);
    while (q_len.size() != 0 || mon_busy || !tx_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(thr_empty == 1'b1, "R1 reset thr_empty", thr_empty, 1);
    chk(tx_empty == 1'b1, "R1 reset tx_empty", tx_empty, 1);
    repeat (20) @(negedge clk);
    chk(txd == 1'b1, "R1 idle line", txd, 1);

    lcr = 8'h03;
    send(8'hA5, "R2 8N1 A5"); send(8'h3C, "R2 8N1 3C"); drain();

    lcr = 8'h00; send(8'hFF, "R3 5bit FF"); send(8'hE6, "R3 5bit E6"); drain();
    lcr = 8'h01; send(8'h5A, "R3 6bit 5A"); drain();
    lcr = 8'h02; send(8'hC3, "R3 7bit C3"); drain();

    lcr = 8'h07; send(8'h81, "R4 8bit two stop"); drain();
    lcr = 8'h04; send(8'h15, "R4 5bit two stop"); drain();

    lcr = 8'h33; send(8'h01, "R5 parity off with stick/even"); drain();
    lcr = 8'h13; send(8'h07, "R5 parity off with even"); drain();

    lcr = 8'h0B; send(8'h00, "R6 odd 00"); send(8'h01, "R6 odd 01"); drain();
    lcr = 8'h1B; send(8'h00, "R6 even 00"); send(8'h03, "R6 even 03"); drain();
    lcr = 8'h1A; send(8'h7F, "R6 even 7bit 7F"); drain();

    lcr = 8'h2B; send(8'h01, "R7 stick one"); send(8'h00, "R7 stick one 00"); drain();
    lcr = 8'h3B; send(8'h00, "R7 stick zero"); send(8'h01, "R7 stick zero 01"); drain();

    lcr = 8'h9B; send(8'h6E, "R10 dlab set"); drain();

    tick_p = 3;
    lcr = 8'h0F; send(8'h12, "R2 spaced tick a"); send(8'hED, "R2 spaced tick b"); drain();
    tick_p = 1;

    // R9 flag sequencing
    lcr = 8'h03;
    begin
      logic [15:0] b;
      int n;
      exp_frame(8'h55, lcr, b, n);
      q_bits.push_back(b); q_len.push_back(n); q_tag.push_back("R9 frame");
      wr_data = 8'h55; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(thr_empty == 1'b0, "R9 thr_empty after write", thr_empty, 0);
      chk(tx_empty == 1'b0, "R9 tx_empty after write", tx_empty, 0);
      @(negedge clk);
      chk(thr_empty == 1'b1, "R9 thr_empty after move", thr_empty, 1);
      chk(tx_empty == 1'b0, "R9 tx_empty while shifting", tx_empty, 0);
      drain();
      chk(tx_empty == 1'b1, "R9 tx_empty after frame", tx_empty, 1);
    end

    // R8 break
    begin
      bit saw_high;
      mon_en = 1'b0;
      lcr = 8'h43;
      @(negedge clk); @(negedge clk);
      chk(txd == 1'b0, "R8 break idle", txd, 0);
      wr_data = 8'hFF; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      saw_high = 1'b0;
      for (int c = 1; c < 100; c++) begin
        if (txd) saw_high = 1'b1;
        @(negedge clk);
      end
      chk(!saw_high, "R8 line held low", saw_high, 0);
      chk(tx_empty == 1'b0, "R8 frame still running", tx_empty, 0);
      lcr = 8'h03;
      repeat (50) @(negedge clk);
      chk(txd == 1'b1, "R8 released mid frame", txd, 1);
      chk(tx_empty == 1'b0, "R8 frame timing kept", tx_empty, 0);
      repeat (20) @(negedge clk);
      chk(tx_empty == 1'b1, "R8 frame ended on time", tx_empty, 1);
      prev_txd = txd;
      mon_en = 1'b1;
    end

    lcr = 8'h03; send(8'h99, "R2 after break"); drain();
    finish_up();
  end
endmodule